// File: doc/BRIEF.md
# Partial Transfer Length Report Queue

This block keeps a short log of transfers that finished before their programmed length because the incoming stream marked end of packet early. Each logged record pairs the transfer ID with the number of bytes that were actually moved. Records wait in a four-entry first-in first-out queue until software collects them.

Software reads through two read-data ports. One returns the byte count of the oldest record and the other returns its ID. A pending flag, which drives the top bit of the completion status word, stays high while any record is still unread. Software first reads the length and then the ID, and repeats that pair until the flag drops. Reading the ID removes the record. Logging is done only for transfers whose partial-report flag is set. The normal completion bit of such a transfer is handled elsewhere and is not affected by this block. The block moves no data of its own.

Top module: `partial_len_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `pending` and `overflow` are 0, and `len_rdata` and `id_rdata` read 0.
- R2: A record is stored only when `ev_valid` and `ev_report_en` are both high in the same cycle. An event with `ev_report_en` low leaves the queue unchanged.
- R3: `id_rdata[4:0]` carries the stored transfer ID (0 to 31) and the bits above it read 0. `len_rdata[LEN_W-1:0]` carries the stored byte count and the bits above it read 0.
- R4: Records are returned oldest first.
- R5: `pending` is 1 while at least one record is unread and drops to 0 once the last record has been popped.
- R6: A length read never pops. An ID read of a non-empty queue pops exactly one record on the clock edge that ends the strobe cycle, so the record is still visible during that cycle.
- R7: A read of either port while the queue is empty returns 0 and changes nothing. A record pushed later is returned intact.
- R8: The queue holds DEPTH (default 4) records. An accepted event that finds the queue full, with no pop in the same cycle, is dropped and sets `overflow`. `overflow` stays set until reset.
- R9: A push and a pop in the same cycle both take effect. This also holds when the queue is full, so that case is not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Early-end event strobe |
| ev_id | input | 5 | Transfer ID of the event |
| ev_len | input | LEN_W | Bytes actually moved |
| ev_report_en | input | 1 | Partial-report flag of that transfer |
| rd_len_stb | input | 1 | Length register read strobe |
| rd_id_stb | input | 1 | ID register read strobe (pops) |
| len_rdata | output | 32 | Byte count of the oldest record, or 0 |
| id_rdata | output | 32 | ID of the oldest record, or 0 |
| pending | output | 1 | Unread records remain (completion word top bit) |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
The bench targets four cases. The first is a length read repeated several times: a design that popped on that read would lose records and clear `pending` early. The second is an ID read on an empty queue: a design without an empty guard would underflow its count and later return stale records. The third is a push on a full queue: the bench checks both the case that coincides with a pop and the case that does not. A wrong design would either drop the coinciding record and raise `overflow` falsely, or overwrite the oldest record. The fourth is an event with reporting disabled, together with IDs and lengths at their extremes: this catches recording without the enable and truncation of the ID or length fields.

// File: rtl/prq_pkg.sv
// Package for the partial transfer length report queue.
// Holds the widths that are fixed by the register interface.
package prq_pkg;
    localparam int ID_W  = 5;   // transfer IDs 0..31
    localparam int REG_W = 32;  // software register width
    typedef logic [ID_W-1:0]  xfer_id_t;
    typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/prq_storage.sv
// Record storage: a circular queue of (ID, length) records.
// Assumes push is only asserted when room exists after this cycle's pop,
// and pop is only asserted when the queue is non-empty.
module prq_storage
    import prq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 24,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  xfer_id_t         wr_id,
    input  logic [LEN_W-1:0] wr_len,
    output xfer_id_t         head_id,
    output logic [LEN_W-1:0] head_len,
    output logic [CNT_W-1:0] occ
);
    xfer_id_t         id_mem  [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Advance a pointer with wrap at DEPTH (DEPTH need not be a power of two).
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Write the incoming record into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                id_mem[i]  <= '0;
                len_mem[i] <= '0;
            end
        end else if (push) begin
            id_mem[wr_ptr]  <= wr_id;
            len_mem[wr_ptr] <= wr_len;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            occ <= occ + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Present the oldest record.
    always_comb begin
        head_id  = id_mem[rd_ptr];
        head_len = len_mem[rd_ptr];
    end
endmodule

// File: rtl/prq_admit.sv
// Admission control: decides whether an event is stored or dropped, and
// keeps the sticky overflow flag. Assumes occ never exceeds DEPTH.
module prq_admit #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_report_en,
    input  logic             rd_id_stb,
    input  logic [CNT_W-1:0] occ,
    output logic             push,
    output logic             pop,
    output logic             overflow
);
    logic wanted;
    logic room;
    logic drop;

    // Decide push, pop and drop for this cycle.
    always_comb begin
        wanted = ev_valid && ev_report_en;
        pop    = rd_id_stb && (occ != '0);
        room   = (occ < CNT_W'(DEPTH)) || pop;
        push   = wanted && room;
        drop   = wanted && !room;
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
    end
endmodule

// File: rtl/prq_rdmux.sv
// Read-data formatting: zero-extends the head record into register words.
// Returns zero on both ports when the queue is empty.
module prq_rdmux
    import prq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 24,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] occ,
    input  xfer_id_t         head_id,
    input  logic [LEN_W-1:0] head_len,
    output reg_word_t        len_rdata,
    output reg_word_t        id_rdata,
    output logic             pending
);
    reg_word_t len_word;

    // Widen the length field; a field as wide as the register passes through.
    generate
        if (LEN_W < REG_W) begin : g_len_pad
            assign len_word = {{(REG_W - LEN_W){1'b0}}, head_len};
        end else begin : g_len_full
            assign len_word = head_len[REG_W-1:0];
        end
    endgenerate

    // Gate the read data by the non-empty flag.
    always_comb begin
        pending   = (occ != '0);
        len_rdata = pending ? len_word : '0;
        id_rdata  = pending ? {{(REG_W - ID_W){1'b0}}, head_id} : '0;
    end
endmodule

// File: rtl/partial_len_queue.sv
// Top of the partial transfer length report queue. Logs (ID, bytes moved)
// for early-terminated transfers that requested reporting; software drains
// with length-then-ID read pairs. Assumes LEN_W <= 32.
module partial_len_queue
    import prq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 24,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [4:0]       ev_id,
    input  logic [LEN_W-1:0] ev_len,
    input  logic             ev_report_en,
    input  logic             rd_len_stb,
    input  logic             rd_id_stb,
    output logic [31:0]      len_rdata,
    output logic [31:0]      id_rdata,
    output logic             pending,
    output logic             overflow
);
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] occ_q;
    xfer_id_t         head_id;
    logic [LEN_W-1:0] head_len;
    logic             len_read_seen;

    // The length strobe has no side effect; it is sampled only for the checker.
    assign len_read_seen = rd_len_stb;

    prq_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
        .ev_report_en(ev_report_en), .rd_id_stb(rd_id_stb), .occ(occ_q),
        .push(push), .pop(pop), .overflow(overflow)
    );

    prq_storage #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_id(ev_id), .wr_len(ev_len), .head_id(head_id),
        .head_len(head_len), .occ(occ_q)
    );

    prq_rdmux #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rdmux (
        .occ(occ_q), .head_id(head_id), .head_len(head_len),
        .len_rdata(len_rdata), .id_rdata(id_rdata), .pending(pending)
    );
endmodule

// File: rtl/prq_checker.sv
// Assertion checker for partial_len_queue, attached by bind.
module prq_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_report_en,
    input logic             rd_len_stb,
    input logic             rd_id_stb,
    input logic [31:0]      len_rdata,
    input logic [31:0]      id_rdata,
    input logic             pending,
    input logic             overflow,
    input logic [CNT_W-1:0] occ
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!pending && !overflow)); // R1
    AST_NO_ENABLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_report_en && !rd_id_stb) |=> occ == $past(occ)); // R2
    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        id_rdata[31:5] == '0); // R3
    AST_LEN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len_stb && !rd_id_stb && !(ev_valid && ev_report_en))
        |=> occ == $past(occ)); // R6
    AST_ID_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id_stb && pending && !(ev_valid && ev_report_en))
        |=> occ == $past(occ) - CNT_W'(1)); // R6
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (len_rdata == '0 && id_rdata == '0)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)); // R8
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_report_en && occ == CNT_W'(DEPTH) && !rd_id_stb)
        |=> overflow); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_report_en && rd_id_stb && occ == CNT_W'(DEPTH) && !overflow)
        |=> (occ == CNT_W'(DEPTH) && !overflow)); // R9
endmodule

bind partial_len_queue prq_checker #(.DEPTH(DEPTH)) u_prq_checker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
    .ev_report_en(ev_report_en), .rd_len_stb(len_read_seen),
    .rd_id_stb(rd_id_stb), .len_rdata(len_rdata), .id_rdata(id_rdata),
    .pending(pending), .overflow(overflow), .occ(occ_q)
);

// File: tb/test_partial_len_queue.sv
// Directed bench for partial_len_queue: one task per scenario.
module test_partial_len_queue;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_valid = 1'b0;
    logic [4:0]       ev_id = '0;
    logic [LEN_W-1:0] ev_len = '0;
    logic             ev_report_en = 1'b0;
    logic             rd_len_stb = 1'b0;
    logic             rd_id_stb = 1'b0;
    logic [31:0]      len_rdata;
    logic [31:0]      id_rdata;
    logic             pending;
    logic             overflow;

    int n_checks = 0;
    int n_fail   = 0;

    partial_len_queue #(.DEPTH(4), .LEN_W(LEN_W)) i_partial_len_queue (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_id(ev_id),
        .ev_len(ev_len), .ev_report_en(ev_report_en), .rd_len_stb(rd_len_stb),
        .rd_id_stb(rd_id_stb), .len_rdata(len_rdata), .id_rdata(id_rdata),
        .pending(pending), .overflow(overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_ev(input int id, input int len, input bit en);
        @(negedge clk);
        ev_valid = 1'b1; ev_id = 5'(id); ev_len = LEN_W'(len); ev_report_en = en;
        @(negedge clk);
        ev_valid = 1'b0; ev_report_en = 1'b0;
    endtask

    task automatic pop_pair(input int exp_id, input int exp_len, input string req);
        @(negedge clk);
        rd_len_stb = 1'b1;
        #1 chk(len_rdata == 32'(exp_len), req, "length read", len_rdata, exp_len);
        @(negedge clk);
        rd_len_stb = 1'b0; rd_id_stb = 1'b1;
        #1 chk(id_rdata == 32'(exp_id), req, "id read", id_rdata, exp_id);
        @(negedge clk);
        rd_id_stb = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(!pending, "R1", "pending after reset", pending, 0);
        chk(!overflow, "R1", "overflow after reset", overflow, 0);
        chk(len_rdata == 0 && id_rdata == 0, "R1", "read data after reset",
            len_rdata | id_rdata, 0);
    endtask

    task automatic t_single();
        push_ev(7, 100, 1'b1);
        #1 chk(pending, "R5", "pending with one record", pending, 1);
        pop_pair(7, 100, "R3");
        #1 chk(!pending, "R5", "pending after last pop", pending, 0);
    endtask

    task automatic t_ignore();
        push_ev(3, 9, 1'b0);
        #1 chk(!pending, "R2", "pending after disabled event", pending, 0);
        chk(len_rdata == 0, "R2", "length after disabled event", len_rdata, 0);
    endtask

    task automatic t_order();
        push_ev(0, 1, 1'b1);
        push_ev(31, (1 << LEN_W) - 1, 1'b1);
        push_ev(12, 500, 1'b1);
        pop_pair(0, 1, "R4");
        pop_pair(31, (1 << LEN_W) - 1, "R3");
        pop_pair(12, 500, "R4");
        #1 chk(!pending, "R5", "pending after draining three", pending, 0);
    endtask

    task automatic t_len_no_pop();
        push_ev(5, 64, 1'b1);
        @(negedge clk);
        rd_len_stb = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk(len_rdata == 64 && pending, "R6", "length after repeated length reads",
                   len_rdata, 64);
        end
        rd_len_stb = 1'b0;
        rd_id_stb = 1'b1;
        #1 chk(pending && id_rdata == 5, "R6", "record visible during id strobe", id_rdata, 5);
        @(negedge clk);
        rd_id_stb = 1'b0;
        #1 chk(!pending, "R6", "pending after id read", pending, 0);
    endtask

    task automatic t_empty();
        @(negedge clk);
        rd_len_stb = 1'b1;
        #1 chk(len_rdata == 0, "R7", "length on empty", len_rdata, 0);
        @(negedge clk);
        rd_len_stb = 1'b0; rd_id_stb = 1'b1;
        #1 chk(id_rdata == 0, "R7", "id on empty", id_rdata, 0);
        @(negedge clk);
        rd_id_stb = 1'b0;
        #1 chk(!pending, "R7", "pending after empty read", pending, 0);
        push_ev(9, 33, 1'b1);
        pop_pair(9, 33, "R7");
        #1 chk(!pending, "R7", "pending after single record", pending, 0);
    endtask

    task automatic t_simul();
        for (int k = 1; k <= 4; k++) push_ev(k, k * 10, 1'b1);
        @(negedge clk);
        ev_valid = 1'b1; ev_id = 5'd20; ev_len = LEN_W'(200); ev_report_en = 1'b1;
        rd_id_stb = 1'b1;
        #1 chk(id_rdata == 1, "R9", "id during swap", id_rdata, 1);
        @(negedge clk);
        ev_valid = 1'b0; ev_report_en = 1'b0; rd_id_stb = 1'b0;
        #1 chk(!overflow, "R9", "overflow after full swap", overflow, 0);
        pop_pair(2, 20, "R9");
        pop_pair(3, 30, "R9");
        pop_pair(4, 40, "R9");
        pop_pair(20, 200, "R9");
        #1 chk(!pending, "R9", "pending after drain", pending, 0);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 4; k++) push_ev(10 + k, 7 + k, 1'b1);
        #1 chk(!overflow, "R8", "overflow at exactly full", overflow, 0);
        push_ev(14, 99, 1'b1);
        #1 chk(overflow, "R8", "overflow after drop", overflow, 1);
        for (int k = 0; k < 4; k++) pop_pair(10 + k, 7 + k, "R8");
        #1 chk(!pending, "R8", "dropped record absent", pending, 0);
        chk(overflow, "R8", "overflow sticky after drain", overflow, 1);
        do_reset();
        #1 chk(!overflow, "R1", "overflow cleared by reset", overflow, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_ignore();
        t_order();
        t_len_no_pop();
        t_empty();
        t_simul();
        t_overflow();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule